// File: doc/BRIEF.md
# Streaming Packet Framing and Stall Monitor

This block is a passive observer placed beside a single-channel transmit packet stream. It never drives the stream. It samples the valid, ready, start-marker and end-marker lines on every clock edge. It raises a flag when the start and end markers do not pair up, when a marker is raised on a cycle without valid, or when the sink holds ready low for longer than a programmable limit.

Each kind of fault sets its own sticky flag, which stays set until the clear input is raised. A one-cycle pulse marks the first fault seen after the flags were last empty. This pulse can drive an external trigger. The monitor also keeps a small record of the two most recently closed packets, so that after a trigger the framing that led up to the fault can be read straight from the outputs.

Top module: `pkt_proto_mon`

## Requirements
- R1: A beat is a transfer only when valid and ready are both high. Markers on a cycle with valid high and ready low change neither the framing state nor the history outputs.
- R2: A start marker on a transfer while a packet is open sets `err_flags[0]` on the next clock edge. The new start then begins a fresh packet.
- R3: An end marker without a start marker on a transfer, with no packet open, sets `err_flags[1]` on the next edge. This covers a second end marker after a packet has already closed.
- R4: A start or end marker on any cycle with valid low sets `err_flags[2]` on the next edge, whatever the state of ready.
- R5: When ready is low on a cycle that follows at least `STALL_LIMIT` consecutive low-ready cycles, `err_flags[3]` is set on the next edge. A run of exactly `STALL_LIMIT` low cycles does not set it; the cycle after that run does.
- R6: Any cycle with ready high restarts the low-ready count from zero. The count saturates and does not wrap.
- R7: A single transfer that carries both the start and the end marker is a legal one-beat packet. It raises no flag and leaves no packet open.
- R8: Each error flag stays set until `clr` is high. A cycle with `clr` high empties the flags, except for any faults detected on that same cycle, which are set.
- R9: `err_pulse` is high for one cycle, on the edge where faults are detected while the flags, after any clear, were all zero.
- R10: On every transfer with the end marker, `hist_last` takes the record of the packet that closes and `hist_prev` takes the old `hist_last`. A record is {opened-by-start bit, started-over-an-open-packet bit, beat count} and is `BEAT_W+2` bits wide, most significant bit first. The beat count includes the start and end beats and saturates at all ones. An end marker with no packet open is recorded as {0,0,1}.
- R11: A synchronous active-low reset clears the open-packet state, the stall count, the flags, the pulse and both history records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Clears the sticky error flags |
| valid | input | 1 | Stream valid |
| ready | input | 1 | Stream ready from the sink |
| sop | input | 1 | Start-of-packet marker |
| eop | input | 1 | End-of-packet marker |
| err_flags | output | 4 | Sticky flags: [0] double start, [1] orphan end, [2] marker without valid, [3] ready stall |
| err_pulse | output | 1 | One-cycle pulse on the first fault after empty flags |
| hist_last | output | BEAT_W+2 | Record of the most recently closed packet |
| hist_prev | output | BEAT_W+2 | Record of the packet closed before that |

## Verification
The stall boundary is driven with exactly `STALL_LIMIT` low-ready cycles and then with one more. An off-by-one counter would flag one cycle early or one cycle late. A second run is broken by a single ready-high cycle, which catches a counter that fails to restart. A marker sent with valid high and ready low is followed by an end marker. A design that advanced its framing on valid alone would then miss the orphan end and would disturb the history. The bench also covers one-beat packets, a clear raised on the same cycle as a new fault, and random streams with long ready-low runs. These catch a sticky flag that drops, a pulse that repeats while flags are set, and history records that shift on the wrong beat.

// File: rtl/pkt_proto_mon.sv
module pkt_proto_mon #(
  parameter int STALL_LIMIT = 100,
  parameter int BEAT_W      = 8,
  localparam int CNT_W      = $clog2(STALL_LIMIT + 1),
  localparam int REC_W      = BEAT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             valid,
  input  logic             ready,
  input  logic             sop,
  input  logic             eop,
  output logic [3:0]       err_flags,
  output logic             err_pulse,
  output logic [REC_W-1:0] hist_last,
  output logic [REC_W-1:0] hist_prev
);

  logic              in_pkt;
  logic              cur_extra;
  logic [BEAT_W-1:0] cur_beats;
  logic [CNT_W-1:0]  stall_cnt;

  logic              xfer;
  logic [3:0]        det;
  logic [3:0]        flag_base;
  logic [BEAT_W-1:0] nxt_beats;
  logic              nxt_extra;
  logic [REC_W-1:0]  rec;

  assign xfer   = valid & ready;
  assign det[0] = xfer & sop & in_pkt;
  assign det[1] = xfer & eop & ~sop & ~in_pkt;
  assign det[2] = (sop | eop) & ~valid;
  assign det[3] = ~ready & (stall_cnt == CNT_W'(STALL_LIMIT));

  assign flag_base = clr ? 4'b0 : err_flags;

  assign nxt_beats = (sop | ~in_pkt) ? BEAT_W'(1)
                   : (&cur_beats)    ? cur_beats
                   :                   cur_beats + BEAT_W'(1);
  assign nxt_extra = sop ? in_pkt : cur_extra;
  assign rec       = {sop | in_pkt, nxt_extra, nxt_beats};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_cnt <= '0;
    end else if (ready) begin
      stall_cnt <= '0;
    end else if (stall_cnt != CNT_W'(STALL_LIMIT)) begin
      stall_cnt <= stall_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_flags <= flag_base | det;
      err_pulse <= (|det) & ~(|flag_base);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      cur_extra <= 1'b0;
      cur_beats <= '0;
      hist_last <= '0;
      hist_prev <= '0;
    end else if (xfer) begin
      if (eop) begin
        hist_prev <= hist_last;
        hist_last <= rec;
        in_pkt    <= 1'b0;
        cur_extra <= 1'b0;
        cur_beats <= '0;
      end else if (sop | in_pkt) begin
        in_pkt    <= 1'b1;
        cur_extra <= nxt_extra;
        cur_beats <= nxt_beats;
      end
    end
  end

endmodule

// File: rtl/pkt_proto_mon_chk.sv
module pkt_proto_mon_chk #(
  parameter int REC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             valid,
  input logic             ready,
  input logic             sop,
  input logic             eop,
  input logic [3:0]       err_flags,
  input logic             err_pulse,
  input logic [REC_W-1:0] hist_last,
  input logic [REC_W-1:0] hist_prev
);

  p_no_xfer_hist_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && ready) |=> ($stable(hist_last) && $stable(hist_prev)));

  p_marker_novalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sop || eop) && !valid) |=> err_flags[2]);

  p_ready_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !$rose(err_flags[3]));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_pulse_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_flags != 4'b0));

endmodule

bind pkt_proto_mon pkt_proto_mon_chk #(.REC_W(REC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .ready(ready),
  .sop(sop), .eop(eop), .err_flags(err_flags), .err_pulse(err_pulse),
  .hist_last(hist_last), .hist_prev(hist_prev)
);

// File: tb/test_pkt_proto_mon.sv
module test_pkt_proto_mon;
  localparam int LIMIT = 100;
  localparam int BW    = 8;
  localparam int RW    = BW + 2;

  logic clk = 1'b0;
  logic rst_n, clr, valid, ready, sop, eop;
  logic [3:0]    err_flags;
  logic          err_pulse;
  logic [RW-1:0] hist_last, hist_prev;

  int checks = 0;
  int errors = 0;

  bit          m_in, m_extra, m_pulse;
  int          m_beats, m_cnt;
  bit [3:0]    m_flags;
  bit [RW-1:0] m_last, m_prev;

  always #4 clk = ~clk;

  pkt_proto_mon #(.STALL_LIMIT(LIMIT), .BEAT_W(BW)) i_pkt_proto_mon (
    .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .ready(ready),
    .sop(sop), .eop(eop), .err_flags(err_flags), .err_pulse(err_pulse),
    .hist_last(hist_last), .hist_prev(hist_prev)
  );

  function automatic bit [RW-1:0] mk_rec(bit o, bit x, int b);
    return {o, x, BW'(b)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(bit v, bit r, bit s, bit e, bit c);
    bit xf;
    bit [3:0] d, base;
    int nb;
    bit nx;
    if (!rst_n) begin
      m_in = 0; m_extra = 0; m_beats = 0; m_cnt = 0;
      m_flags = 0; m_pulse = 0; m_last = 0; m_prev = 0;
      return;
    end
    xf   = v & r;
    d[0] = xf & s & m_in;
    d[1] = xf & e & !s & !m_in;
    d[2] = (s | e) & !v;
    d[3] = !r && (m_cnt >= LIMIT);
    m_cnt   = r ? 0 : ((m_cnt < LIMIT) ? m_cnt + 1 : m_cnt);
    base    = c ? 4'b0 : m_flags;
    m_pulse = (d != 0) && (base == 0);
    m_flags = base | d;
    if (xf) begin
      nb = (s || !m_in) ? 1 : ((m_beats < (1 << BW) - 1) ? m_beats + 1 : m_beats);
      nx = s ? m_in : m_extra;
      if (e) begin
        m_prev = m_last;
        m_last = mk_rec(s | m_in, nx, nb);
        m_in = 0; m_extra = 0; m_beats = 0;
      end else if (s || m_in) begin
        m_in = 1; m_extra = nx; m_beats = nb;
      end
    end
  endtask

  task automatic step(bit v, bit r, bit s, bit e, bit c = 0);
    valid = v; ready = r; sop = s; eop = e; clr = c;
    @(posedge clk);
    model(v, r, s, e, c);
    #2;
    check("R2 flag0", err_flags[0], m_flags[0]);
    check("R3 flag1", err_flags[1], m_flags[1]);
    check("R4 flag2", err_flags[2], m_flags[2]);
    check("R5 flag3", err_flags[3], m_flags[3]);
    check("R9 pulse", err_pulse, m_pulse);
    check("R10 hist_last", hist_last, m_last);
    check("R10 hist_prev", hist_prev, m_prev);
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] keep;
    void'($urandom(32'd1234));
    rst_n = 0; clr = 0; valid = 0; ready = 0; sop = 0; eop = 0;
    do_reset();
    check("R11 reset flags", err_flags, 0);
    check("R11 reset hist", {hist_last, hist_prev}, 0);

    step(1, 1, 1, 1);
    check("R7 one-beat no flag", err_flags, 0);
    check("R7 one-beat record", hist_last, mk_rec(1, 0, 1));

    keep = hist_last;
    step(1, 0, 1, 0);
    check("R1 held beat hist", hist_last, keep);
    step(1, 1, 0, 1);
    check("R1 start not taken -> orphan", err_flags[1], 1);
    check("R10 orphan record", hist_last, mk_rec(0, 0, 1));
    check("R10 prev shifted", hist_prev, keep);

    step(0, 1, 0, 0, 1);
    check("R8 clear", err_flags, 0);
    step(1, 1, 1, 0); step(1, 1, 0, 0); step(1, 1, 0, 1);
    check("R10 three-beat", hist_last, mk_rec(1, 0, 3));
    step(1, 1, 1, 0); step(1, 1, 1, 0);
    check("R2 double start", err_flags[0], 1);
    check("R9 first pulse", err_pulse, 1);
    step(0, 1, 1, 0);
    check("R4 marker no valid", err_flags[2], 1);
    check("R9 no repeat pulse", err_pulse, 0);
    step(1, 1, 0, 1);
    check("R10 restarted record", hist_last, mk_rec(1, 1, 2));
    step(0, 1, 0, 1, 1);
    check("R8 clear with new fault", err_flags, 4'b0100);
    check("R9 pulse after clear", err_pulse, 1);
    step(0, 1, 0, 0, 1);

    for (int i = 0; i < LIMIT - 1; i++) step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    for (int i = 0; i < LIMIT; i++) step(0, 0, 0, 0);
    check("R6 restart no stall", err_flags[3], 0);
    step(0, 0, 0, 0);
    check("R5 stall after limit", err_flags[3], 1);
    for (int i = 0; i < 300; i++) step(0, 0, 0, 0);
    check("R6 saturated still set", err_flags[3], 1);

    do_reset();
    for (int i = 0; i < 6000; i++) begin
      bit v, r, s, e, c;
      v = ($urandom % 4) != 0;
      r = ($urandom % 5) != 0;
      if (($urandom % 60) == 0) begin
        int n = 90 + $urandom % 20;
        for (int k = 0; k < n; k++) step(0, 0, 0, 0);
      end
      s = ($urandom % 5) == 0;
      e = ($urandom % 5) == 0;
      if (($urandom % 8) != 0) begin
        s = s & v; e = e & v;
      end
      c = ($urandom % 40) == 0;
      if (($urandom % 2000) == 0) do_reset();
      step(v, r, s, e, c);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule